// File: doc/BRIEF.md
# Multiplexed-Address Asynchronous DRAM Access Sequencer

This block sits between a synchronous requester and an asynchronous DRAM whose row and column addresses share one set of pins. A single start pulse carrying a byte address, a direction flag and (for writes) a data byte launches one complete access. The sequencer splits the address into a row part and a column part. It places each part on the shared bus for a programmed number of clocks before the matching strobe falls. It then runs the output-enable and write-enable strobes in the order that the chosen cycle type needs, and ends the access by raising every strobe together.

Read data is sampled on the last clock of the column-strobe phase. It is presented on the result port together with a one-clock done pulse, and it stays there until the next read completes. The setup, hold, access and minimum cycle times are parameters counted in clocks. A per-request mode bit selects early-read ordering (output enable before the column strobe) or late-read ordering (output enable after it). While `busy` is high, a start is refused.

Top module: `dram_seq`

## Requirements
- R1: While reset is held and after it is released: `ram_ras_n`, `ram_cas_n`, `ram_we_n` and `ram_oe_n` are 1, `ram_dq_oe` is 0, `ram_addr` is 0, `done` and `busy` are 0, and `rd_data` is 0.
- R2: A start is accepted on a clock edge where `req_start`=1 and `busy`=0; that edge is k=0. For k in [0, T_SETUP-1], `ram_addr` carries the row field with all strobes high. For k in [T_SETUP, T_SETUP+T_HOLD-1], `ram_ras_n`=0 and the row field stays on the bus.
- R3: For k in [T_SETUP+T_HOLD, 2*T_SETUP+T_HOLD-1], the column field is on `ram_addr` with `ram_ras_n`=0 and `ram_cas_n`=1. The column field stays on the bus while `ram_cas_n` is low.
- R4: `ram_cas_n`=0 for exactly T_ACCESS clocks, k in [2*T_SETUP+T_HOLD, E-1] with E=2*T_SETUP+T_HOLD+T_ACCESS. On a read, `rd_data` at k=E equals the value of `ram_dq_in` sampled at the clock edge that ends the column-strobe phase.
- R5: Early read (`req_late`=0 at acceptance): `ram_oe_n`=0 from the first column-setup clock through the last column-strobe clock.
- R6: Late read (`req_late`=1 at acceptance): `ram_oe_n` stays 1 through column setup and through the first column-strobe clock, then is 0 for the rest of the column-strobe phase. The mode is taken only at acceptance.
- R7: Write (`req_rd`=0): from the first column-setup clock through the last column-strobe clock, `ram_we_n`=0 and `ram_dq_oe`=1 with the write byte on `ram_dq_out`; `ram_oe_n` stays 1 for the whole access.
- R8: Read (`req_rd`=1): `ram_we_n` stays 1 and `ram_dq_oe` stays 0 for the whole access. Outside the write window, `ram_dq_out` is 0.
- R9: At k=E, `done`=1 for one clock, all strobes are 1 and `ram_addr` is 0. At k=E+1 the block is idle.
- R10: `busy`=1 for k in [0, max(T_CYCLE, E+1)-1] and 0 afterwards. A start seen while `busy`=1 is ignored and changes no output.
- R11: Row field = address bits [20:9]; column field = address bits [8:0], driven on bus bits [8:0] with bus bits [11:9] zero.
- R12: `rd_data` changes only at the completion of a read; writes and ignored starts leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_start | input | 1 | Start request, sampled when busy is low |
| req_rd | input | 1 | 1 = read, 0 = write |
| req_late | input | 1 | 1 = late-read ordering, 0 = early-read ordering |
| req_addr | input | 21 | Byte address |
| req_wdata | input | 8 | Write byte |
| busy | output | 1 | Request refused while high |
| done | output | 1 | One-clock completion pulse |
| rd_data | output | 8 | Last captured read byte |
| ram_addr | output | 12 | Shared row/column address bus |
| ram_ras_n | output | 1 | Row strobe, active low |
| ram_cas_n | output | 1 | Column strobe, active low |
| ram_we_n | output | 1 | Write enable, active low |
| ram_oe_n | output | 1 | Output enable, active low |
| ram_dq_out | output | 8 | Data driven toward the DRAM |
| ram_dq_oe | output | 1 | Drive enable for ram_dq_out |
| ram_dq_in | input | 8 | Data returned by the DRAM |

## Verification
The bound checker watches, on every clock, the invariants that relate strobes to one another. The column strobe never falls without the row strobe already low. Output enable and write enable are never low together, and write enable is low only while data is driven. The bus is stable on each strobe's falling edge. Done coincides with the rising edge of the column strobe, lasts one clock, and finds every strobe high. When busy is low, the strobes are idle.

The exact clock counts of each phase, the difference between early and late output enable, the captured value, the refusal window measured from the previous start, and the retention of read data across writes depend on the request history. Only the bench's per-clock reference model can show these.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_ROW_SU = 3'd1,
        PH_ROW_HD = 3'd2,
        PH_COL_SU = 3'd3,
        PH_STROBE = 3'd4,
        PH_FINISH = 3'd5
    } phase_e;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/dram_seq_addr_split.sv
module dram_seq_addr_split #(
    parameter int ADDR_W = 21,
    parameter int COL_W  = 9,
    localparam int ROW_W = ADDR_W - COL_W
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ROW_W-1:0]  row_o,
    output logic [COL_W-1:0]  col_o
);

    // Upper bits select the row, lower bits select the column group.
    always_comb begin
        row_o = addr_i[ADDR_W-1:COL_W];
        col_o = addr_i[COL_W-1:0];
    end

endmodule

// File: rtl/dram_seq_guard.sv
module dram_seq_guard #(
    parameter int T_CYCLE = 14,
    localparam int GW = $clog2(T_CYCLE + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic accept_i,
    output logic window_open_o
);

    logic [GW-1:0] gcnt_d, gcnt_q;

    // The count is loaded on every accepted start and runs down to zero.
    always_comb begin
        gcnt_d = gcnt_q;
        if (accept_i) begin
            gcnt_d = GW'(T_CYCLE);
        end else if (gcnt_q != '0) begin
            gcnt_d = gcnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gcnt_q <= '0;
        end else begin
            gcnt_q <= gcnt_d;
        end
    end

    assign window_open_o = (gcnt_q == '0);

endmodule

// File: rtl/dram_seq_fsm.sv
module dram_seq_fsm
    import dram_seq_pkg::*;
#(
    parameter int ROW_W    = 12,
    parameter int COL_W    = 9,
    parameter int DATA_W   = 8,
    parameter int T_SETUP  = 2,
    parameter int T_HOLD   = 2,
    parameter int T_ACCESS = 4,
    parameter int CNT_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept_i,
    input  logic              rd_i,
    input  logic              late_i,
    input  logic [ROW_W-1:0]  row_i,
    input  logic [COL_W-1:0]  col_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [DATA_W-1:0] dq_in_i,
    output logic              idle_o,
    output logic              done_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic [ROW_W-1:0]  bus_o,
    output logic              ras_n_o,
    output logic              cas_n_o,
    output logic              we_n_o,
    output logic              oe_n_o,
    output logic [DATA_W-1:0] dq_out_o,
    output logic              dq_oe_o
);

    typedef struct packed {
        phase_e             ph;
        logic [CNT_W-1:0]   cnt;
        logic [ROW_W-1:0]   row;
        logic [COL_W-1:0]   col;
        logic               rd;
        logic               late;
        logic [DATA_W-1:0]  wdata;
        logic [ROW_W-1:0]   bus;
        logic               ras_n;
        logic               cas_n;
        logic               we_n;
        logic               oe_n;
        logic               dq_oe;
        logic [DATA_W-1:0]  dq_out;
        logic               done;
        logic [DATA_W-1:0]  rdata;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        unique case (s_q.ph)
            PH_IDLE: begin
                if (accept_i) begin
                    s_d.ph    = PH_ROW_SU;
                    s_d.cnt   = CNT_W'(T_SETUP - 1);
                    s_d.row   = row_i;
                    s_d.col   = col_i;
                    s_d.rd    = rd_i;
                    s_d.late  = late_i;
                    s_d.wdata = wdata_i;
                    s_d.bus   = row_i;
                end
            end
            PH_ROW_SU: begin
                if (s_q.cnt == '0) begin
                    s_d.ph    = PH_ROW_HD;
                    s_d.cnt   = CNT_W'(T_HOLD - 1);
                    s_d.ras_n = 1'b0;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            PH_ROW_HD: begin
                if (s_q.cnt == '0) begin
                    s_d.ph  = PH_COL_SU;
                    s_d.cnt = CNT_W'(T_SETUP - 1);
                    s_d.bus = ROW_W'(s_q.col);
                    if (s_q.rd) begin
                        s_d.oe_n = s_q.late;
                    end else begin
                        s_d.we_n   = 1'b0;
                        s_d.dq_oe  = 1'b1;
                        s_d.dq_out = s_q.wdata;
                    end
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            PH_COL_SU: begin
                if (s_q.cnt == '0) begin
                    s_d.ph    = PH_STROBE;
                    s_d.cnt   = CNT_W'(T_ACCESS - 1);
                    s_d.cas_n = 1'b0;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            PH_STROBE: begin
                // Late ordering: enable output one clock after the column strobe fell.
                if (s_q.rd) begin
                    s_d.oe_n = 1'b0;
                end
                if (s_q.cnt == '0) begin
                    s_d.ph     = PH_FINISH;
                    s_d.done   = 1'b1;
                    s_d.bus    = '0;
                    s_d.ras_n  = 1'b1;
                    s_d.cas_n  = 1'b1;
                    s_d.we_n   = 1'b1;
                    s_d.oe_n   = 1'b1;
                    s_d.dq_oe  = 1'b0;
                    s_d.dq_out = '0;
                    if (s_q.rd) begin
                        s_d.rdata = dq_in_i;
                    end
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            PH_FINISH: begin
                s_d.ph = PH_IDLE;
            end
            default: begin
                s_d.ph = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.ph    <= PH_IDLE;
            s_q.ras_n <= 1'b1;
            s_q.cas_n <= 1'b1;
            s_q.we_n  <= 1'b1;
            s_q.oe_n  <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign idle_o   = (s_q.ph == PH_IDLE);
    assign done_o   = s_q.done;
    assign rdata_o  = s_q.rdata;
    assign bus_o    = s_q.bus;
    assign ras_n_o  = s_q.ras_n;
    assign cas_n_o  = s_q.cas_n;
    assign we_n_o   = s_q.we_n;
    assign oe_n_o   = s_q.oe_n;
    assign dq_out_o = s_q.dq_out;
    assign dq_oe_o  = s_q.dq_oe;

endmodule

// File: rtl/dram_seq.sv
module dram_seq
    import dram_seq_pkg::*;
#(
    parameter int ADDR_W   = 21,
    parameter int COL_W    = 9,
    parameter int DATA_W   = 8,
    parameter int T_SETUP  = 2,
    parameter int T_HOLD   = 2,
    parameter int T_ACCESS = 4,
    parameter int T_CYCLE  = 14,
    localparam int ROW_W   = ADDR_W - COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_start,
    input  logic              req_rd,
    input  logic              req_late,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic [ROW_W-1:0]  ram_addr,
    output logic              ram_ras_n,
    output logic              ram_cas_n,
    output logic              ram_we_n,
    output logic              ram_oe_n,
    output logic [DATA_W-1:0] ram_dq_out,
    output logic              ram_dq_oe,
    input  logic [DATA_W-1:0] ram_dq_in
);

    localparam int T_MAX = max3(T_SETUP, T_HOLD, T_ACCESS);
    localparam int CNT_W = (T_MAX > 1) ? $clog2(T_MAX) : 1;

    logic [ROW_W-1:0] row_f;
    logic [COL_W-1:0] col_f;
    logic             seq_idle;
    logic             win_open;
    logic             accept;

    assign busy   = !(seq_idle && win_open);
    assign accept = req_start && !busy;

    dram_seq_addr_split #(
        .ADDR_W (ADDR_W),
        .COL_W  (COL_W)
    ) split_i (
        .addr_i (req_addr),
        .row_o  (row_f),
        .col_o  (col_f)
    );

    dram_seq_guard #(
        .T_CYCLE (T_CYCLE)
    ) guard_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .accept_i      (accept),
        .window_open_o (win_open)
    );

    dram_seq_fsm #(
        .ROW_W    (ROW_W),
        .COL_W    (COL_W),
        .DATA_W   (DATA_W),
        .T_SETUP  (T_SETUP),
        .T_HOLD   (T_HOLD),
        .T_ACCESS (T_ACCESS),
        .CNT_W    (CNT_W)
    ) fsm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept_i (accept),
        .rd_i     (req_rd),
        .late_i   (req_late),
        .row_i    (row_f),
        .col_i    (col_f),
        .wdata_i  (req_wdata),
        .dq_in_i  (ram_dq_in),
        .idle_o   (seq_idle),
        .done_o   (done),
        .rdata_o  (rd_data),
        .bus_o    (ram_addr),
        .ras_n_o  (ram_ras_n),
        .cas_n_o  (ram_cas_n),
        .we_n_o   (ram_we_n),
        .oe_n_o   (ram_oe_n),
        .dq_out_o (ram_dq_out),
        .dq_oe_o  (ram_dq_oe)
    );

endmodule

// File: rtl/dram_seq_chk.sv
module dram_seq_chk #(
    parameter int AW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          done,
    input logic [AW-1:0] ram_addr,
    input logic          ram_ras_n,
    input logic          ram_cas_n,
    input logic          ram_we_n,
    input logic          ram_oe_n,
    input logic          ram_dq_oe
);

    // R3
    cas_needs_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_cas_n |-> !ram_ras_n);

    // R7
    oe_we_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(~ram_oe_n && ~ram_we_n));

    // R7
    we_with_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_we_n |-> ram_dq_oe);

    // R2
    row_stable_at_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ram_ras_n) |-> $stable(ram_addr));

    // R3
    col_stable_at_cas_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ram_cas_n) |-> $stable(ram_addr));

    // R4
    done_at_cas_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ram_cas_n) |-> done);

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    done_strobes_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (ram_ras_n && ram_cas_n && ram_we_n && ram_oe_n && !ram_dq_oe));

    // R10
    idle_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (ram_ras_n && ram_cas_n && ram_we_n && ram_oe_n));

endmodule

bind dram_seq dram_seq_chk #(.AW(ROW_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .ram_addr  (ram_addr),
    .ram_ras_n (ram_ras_n),
    .ram_cas_n (ram_cas_n),
    .ram_we_n  (ram_we_n),
    .ram_oe_n  (ram_oe_n),
    .ram_dq_oe (ram_dq_oe)
);

// File: tb/dram_seq_tb_top.sv
`timescale 1ns/1ps
module dram_seq_tb_top;

    localparam int S = 2, H = 2, A = 4, C = 14;
    localparam int E = 2*S + H + A;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_start = 1'b0, req_rd = 1'b0, req_late = 1'b0;
    logic [20:0] req_addr = '0;
    logic [7:0]  req_wdata = '0, ram_dq_in = '0;
    logic        busy, done, ram_ras_n, ram_cas_n, ram_we_n, ram_oe_n, ram_dq_oe;
    logic [7:0]  rd_data, ram_dq_out;
    logic [11:0] ram_addr;

    always #5 clk = ~clk;

    dram_seq dut_i (.*);

    int errors = 0, checks = 0, cyc = 0;
    bit finished = 0;

    // reference model state
    bit          m_act = 0;
    int          m_s = 0;
    bit          m_rd = 0, m_late = 0;
    logic [20:0] m_addr = '0;
    logic [7:0]  m_wd = '0, m_rdata = '0;

    function automatic bit m_busy();
        int k;
        k = cyc - m_s;
        return m_act && ((k < C) || (k <= E));
    endfunction

    always @(posedge clk) begin
        bit b;
        b = m_busy();
        cyc = cyc + 1;
        if (!rst_n) begin
            m_act = 0;
        end else if (req_start && !b) begin
            m_act = 1; m_s = cyc; m_rd = req_rd; m_late = req_late;
            m_addr = req_addr; m_wd = req_wdata;
            if (req_rd) ram_dq_in <= req_addr[7:0] ^ req_addr[20:13];
        end
        if (rst_n && m_act && (cyc - m_s == E) && m_rd)
            m_rdata = m_addr[7:0] ^ m_addr[20:13];
    end

    task automatic chk(input string tag, input string nm, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s at cycle %0d: actual=%0h expected=%0h", tag, nm, cyc, act, exp);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        int k;
        logic [11:0] e_addr;
        bit e_ras, e_cas, e_we, e_oe, e_dqoe, e_done;
        logic [7:0] e_dq;
        if (rst_n && !finished) begin
            k = cyc - m_s;
            e_addr = '0; e_ras = 1; e_cas = 1; e_we = 1; e_oe = 1; e_dqoe = 0; e_done = 0; e_dq = '0;
            if (m_act && k <= E) begin
                if (k < S + H) e_addr = m_addr[20:9];                 // R11
                else if (k < E) e_addr = {3'b000, m_addr[8:0]};      // R11
                if (k >= S && k < E) e_ras = 0;                       // R2
                if (k >= 2*S + H && k < E) e_cas = 0;                 // R4
                if (k >= S + H && k < E) begin
                    if (m_rd) e_oe = m_late ? !(k > 2*S + H) : 1'b0;  // R5 R6
                    else begin e_we = 0; e_dqoe = 1; e_dq = m_wd; end // R7
                end
                e_done = (k == E);                                    // R9
            end
            chk("R2/R3/R11", "ram_addr", ram_addr, e_addr);
            chk("R2", "ram_ras_n", ram_ras_n, e_ras);
            chk("R4", "ram_cas_n", ram_cas_n, e_cas);
            chk("R5/R6", "ram_oe_n", ram_oe_n, e_oe);
            chk("R7/R8", "ram_we_n", ram_we_n, e_we);
            chk("R7/R8", "ram_dq_oe", ram_dq_oe, e_dqoe);
            chk("R8", "ram_dq_out", ram_dq_out, e_dq);
            chk("R9", "done", done, e_done);
            chk("R10", "busy", busy, m_busy());
            chk("R12", "rd_data", rd_data, m_rdata);
        end
    end

    task automatic request(input bit rd, input bit late, input logic [20:0] a, input logic [7:0] wd);
        while (m_busy()) @(negedge clk);
        req_start = 1; req_rd = rd; req_late = late; req_addr = a; req_wdata = wd;
        @(negedge clk);
        req_start = 0;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: values while reset is held
        chk("R1", "ras/cas/we/oe", {ram_ras_n, ram_cas_n, ram_we_n, ram_oe_n}, 4'hF);
        chk("R1", "dq_oe/done/busy", {ram_dq_oe, done, busy}, 0);
        chk("R1", "rd_data", rd_data, 0);
        chk("R1", "ram_addr", ram_addr, 0);
        rst_n = 1;
        repeat (2) @(negedge clk);
        request(1, 0, 21'h000000, 8'h00);          // R5 early read, zero address
        request(1, 1, 21'h1FFFFF, 8'h00);          // R6 late read, all-ones address
        request(0, 0, 21'h0AAAA, 8'h5A);           // R7 write; R12 rd_data kept
        request(1, 0, 21'h15555, 8'h00);           // R11 alternate split pattern
        // R10: start held high, accepted again exactly when window opens
        while (m_busy()) @(negedge clk);
        req_start = 1; req_rd = 1; req_late = 0; req_addr = 21'h12345;
        repeat (40) @(negedge clk);
        req_start = 0;
        // R10: stray write pulse mid-read is ignored; R6 mode toggled mid-access
        request(1, 1, 21'h0F0F0, 8'h00);
        repeat (3) @(negedge clk);
        req_late = 0;
        req_start = 1; req_rd = 0; req_wdata = 8'hC3; req_addr = 21'h1ABCD;
        @(negedge clk);
        req_start = 0;
        request(0, 1, 21'h00200, 8'hA5);           // R12 write after read
        repeat (25) @(negedge clk);
        summary();
    end

endmodule